// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Two-Stage Prescaler

This block is the timekeeping core of a real-time clock. It runs entirely on a slow oscillator clock. A first divider turns that clock into a tick stream. A second divider counts those ticks down and reloads once per second. Its running count can be read back as a fine-grained subsecond value. Each reload advances a packed BCD hours/minutes/seconds register, which rolls over from 23:59:59 to 00:00:00.

Software reaches the block over a simple register bus. Address, write strobe and write data are sampled on the clock edge, and read data is combinational on the address. The control, status, prescaler and time registers only take writes after a two-byte unlock key. The prescaler and the time value can only be changed after an init request has been acknowledged, which stops the counters. A control bit selects whether time and subsecond reads return the live counters or a copy registered one cycle earlier.

Top module: `rtc_core`

## Requirements
- R1: Out of reset the time reads 0x000000, control and status read 0, the prescaler reads the reset divider values (asynchronous at bit 16 upward, synchronous in the low bits), subsecond reads the synchronous reset value, and the block is locked.
- R2: Register offsets: time 0x00, control 0x08, status 0x0C, prescaler 0x10, key 0x24, subsecond 0x28. Writing 0xCA and then 0x53 to the key unlocks. Any other key value relocks the block, and so does a wrong value between the two keys. Writing 0xCA always restarts the sequence.
- R3: While locked, writes to control, status, prescaler and time have no effect.
- R4: Status bit 7 is the init request and bit 6 the init acknowledge. The acknowledge reads 1 from the third sample after the request write edge (two edges later). Once the request is cleared, the acknowledge reads 0 from the second edge on. While a request or acknowledge is pending, time and subsecond hold and subsecond reads the synchronous divider value.
- R5: Prescaler and time writes take effect only in a cycle where the acknowledge is already high. At any other time they are ignored, even when unlocked.
- R6: With asynchronous value A and synchronous value S, counting resumes on the second edge after the request is cleared. After n counted edges the subsecond reads S - (floor(n/(A+1)) mod (S+1)).
- R7: After n counted edges the time has advanced by floor(n/((A+1)(S+1))) seconds in BCD. Hour tens is at bits 21:20, hour units at 19:16, minute tens at 14:12, minute units at 11:8, second tens at 6:4 and second units at 3:0, and the count wraps from 23:59:59 to 00:00:00.
- R8: The seconds field advances on the same edge at which the subsecond count reloads from 0 to S.
- R9: With control bit 5 at 1, time and subsecond reads return the live counters. With it at 0 they return the values the counters held one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the register at bus_addr |

## Verification
The bench builds the core with a 3-bit asynchronous field, a 4-bit synchronous field and reset dividers 1 and 9. That keeps every divider ratio small enough that each subsecond step and each seconds carry can be sampled cycle by cycle against an arithmetic model. With both dividers at zero, one second passes per clock, so a full 86400-second day runs through, including the midnight wrap. Other runs place the start time just before minute, hour, ten-hour and day boundaries, once in live-read mode and once in delayed-read mode.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam logic [7:0] ADDR_TIME   = 8'h00;
  localparam logic [7:0] ADDR_CTRL   = 8'h08;
  localparam logic [7:0] ADDR_STAT   = 8'h0C;
  localparam logic [7:0] ADDR_PRE    = 8'h10;
  localparam logic [7:0] ADDR_KEY    = 8'h24;
  localparam logic [7:0] ADDR_SUBSEC = 8'h28;

  localparam logic [7:0] KEY_FIRST  = 8'hCA;
  localparam logic [7:0] KEY_SECOND = 8'h53;

  localparam int CTRL_LIVE_BIT = 5;
  localparam int STAT_REQ_BIT  = 7;
  localparam int STAT_ACK_BIT  = 6;
  localparam int PRE_ASYNC_LSB = 16;

  localparam int TOD_W = 22;
  localparam logic [TOD_W-1:0] TOD_MASK     = 22'h3F7F7F;
  localparam logic [TOD_W-1:0] TOD_LAST_SEC = 22'h235959;

  typedef enum logic [1:0] {LK_SHUT, LK_HALF, LK_OPEN} lock_state_t;

  // One-second BCD advance with ripple carry and a wrap at 23:59:59.
  function automatic logic [TOD_W-1:0] tod_next(input logic [TOD_W-1:0] t);
    logic [1:0] ht; logic [3:0] hu;
    logic [2:0] mt; logic [3:0] mu;
    logic [2:0] st; logic [3:0] su;
    ht = t[21:20]; hu = t[19:16];
    mt = t[14:12]; mu = t[11:8];
    st = t[6:4];   su = t[3:0];
    if (su != 4'd9) su = su + 4'd1;
    else begin
      su = 4'd0;
      if (st != 3'd5) st = st + 3'd1;
      else begin
        st = 3'd0;
        if (mu != 4'd9) mu = mu + 4'd1;
        else begin
          mu = 4'd0;
          if (mt != 3'd5) mt = mt + 3'd1;
          else begin
            mt = 3'd0;
            if (ht == 2'd2 && hu == 4'd3) begin
              ht = 2'd0; hu = 4'd0;
            end else if (hu == 4'd9) begin
              hu = 4'd0; ht = ht + 2'd1;
            end else hu = hu + 4'd1;
          end
        end
      end
    end
    return {ht, hu, 1'b0, mt, mu, 1'b0, st, su};
  endfunction

endpackage

// File: rtl/rtc_key_lock.sv
module rtc_key_lock
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_we,
  input  logic [7:0] key_data,
  output logic       unlocked
);

  lock_state_t state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= LK_SHUT;
    else if (key_we) begin
      if (key_data == KEY_FIRST) state <= LK_HALF;
      else if (key_data == KEY_SECOND && state == LK_HALF) state <= LK_OPEN;
      else state <= LK_SHUT;
    end
  end

  assign unlocked = (state == LK_OPEN);

  // R2: opening only ever follows a second-key write
  a_r2_open_after_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_we && key_data == KEY_SECOND));

  // R2: any key write other than the second key leaves the block locked
  a_r2_relock: assert property (@(posedge clk) disable iff (!rst_n)
    (key_we && key_data != KEY_SECOND) |=> !unlocked);

endmodule

// File: rtl/rtc_init_hs.sv
module rtc_init_hs (
  input  logic clk,
  input  logic rst_n,
  input  logic req_we,
  input  logic req_wval,
  output logic init_req,
  output logic init_ack,
  output logic halt
);

  logic req_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_req <= 1'b0;
      req_seen <= 1'b0;
      init_ack <= 1'b0;
    end else begin
      if (req_we) init_req <= req_wval;
      req_seen <= init_req;
      init_ack <= req_seen && init_req;
    end
  end

  // counters stay frozen until the acknowledge has dropped again
  assign halt = init_req || init_ack;

  // R4: acknowledge rises only after two cycles of request
  a_r4_ack_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_ack) |-> ($past(init_req) && $past(init_req, 2)));

  // R4: acknowledge drops one cycle after the request is gone
  a_r4_ack_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !init_req |=> !init_ack);

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int AW   = 7,
  parameter int SW   = 15,
  parameter int ARST = 1,
  parameter int SRST = 19999
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt,
  input  logic          pre_we,
  input  logic [AW-1:0] a_wval,
  input  logic [SW-1:0] s_wval,
  output logic [AW-1:0] a_div,
  output logic [SW-1:0] s_div,
  output logic [SW-1:0] subsec,
  output logic          sec_step
);

  localparam logic [AW-1:0] A_INIT = AW'(ARST);
  localparam logic [SW-1:0] S_INIT = SW'(SRST);

  logic [AW-1:0] a_cnt;
  logic [SW-1:0] s_cnt;
  logic          tick;

  assign tick     = !halt && (a_cnt == '0);
  assign sec_step = tick && (s_cnt == '0);
  assign subsec   = s_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_div <= A_INIT;
      s_div <= S_INIT;
      a_cnt <= A_INIT;
      s_cnt <= S_INIT;
    end else begin
      if (pre_we) begin
        a_div <= a_wval;
        s_div <= s_wval;
      end
      if (halt) begin
        a_cnt <= a_div;
        s_cnt <= s_div;
      end else begin
        a_cnt <= (a_cnt == '0) ? a_div : a_cnt - AW'(1);
        if (tick) s_cnt <= (s_cnt == '0) ? s_div : s_cnt - SW'(1);
      end
    end
  end

  // R8: the second boundary reloads the subsecond count
  a_r8_step_reload: assert property (@(posedge clk) disable iff (!rst_n)
    sec_step |=> (subsec == s_div));

  // R6: a running subsecond count never exceeds its divider value
  a_r6_subsec_range: assert property (@(posedge clk) disable iff (!rst_n)
    !halt |-> (subsec <= s_div));

endmodule

// File: rtl/rtc_tod.sv
module rtc_tod
  import rtc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             tod_we,
  input  logic [TOD_W-1:0] tod_wval,
  output logic [TOD_W-1:0] tod
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tod <= '0;
    else if (tod_we) tod <= tod_wval & TOD_MASK;
    else if (step) tod <= tod_next(tod);
  end

  // R7: the last second of the day rolls over to midnight
  a_r7_midnight: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !tod_we && tod == TOD_LAST_SEC) |=> (tod == '0));

  // R7: every second step changes the time value
  a_r7_step_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !tod_we) |=> (tod != $past(tod)));

endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_pkg::*;
#(
  parameter int AW   = 7,
  parameter int SW   = 15,
  parameter int ARST = 1,
  parameter int SRST = 19999
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);

  localparam logic [SW-1:0] S_INIT = SW'(SRST);

  logic             unlocked, init_req, init_ack, halt, sec_step;
  logic             key_we, prot_we, req_we, pre_we, tod_we;
  logic             live_rd;
  logic [AW-1:0]    a_div;
  logic [SW-1:0]    s_div, subsec, ss_sh;
  logic [TOD_W-1:0] tod, tod_sh;
  logic             unused_wbits;

  assign unused_wbits = ^bus_wdata;

  assign key_we  = bus_wr && (bus_addr == ADDR_KEY);
  assign prot_we = bus_wr && unlocked;
  assign req_we  = prot_we && (bus_addr == ADDR_STAT);
  assign pre_we  = prot_we && (bus_addr == ADDR_PRE)  && init_ack;
  assign tod_we  = prot_we && (bus_addr == ADDR_TIME) && init_ack;

  rtc_key_lock u_lock (
    .clk, .rst_n, .key_we, .key_data(bus_wdata[7:0]), .unlocked
  );

  rtc_init_hs u_init (
    .clk, .rst_n, .req_we, .req_wval(bus_wdata[STAT_REQ_BIT]),
    .init_req, .init_ack, .halt
  );

  rtc_prescaler #(.AW(AW), .SW(SW), .ARST(ARST), .SRST(SRST)) u_pre (
    .clk, .rst_n, .halt, .pre_we,
    .a_wval(bus_wdata[PRE_ASYNC_LSB +: AW]), .s_wval(bus_wdata[SW-1:0]),
    .a_div, .s_div, .subsec, .sec_step
  );

  rtc_tod u_tod (
    .clk, .rst_n, .step(sec_step), .tod_we, .tod_wval(bus_wdata[TOD_W-1:0]), .tod
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_rd <= 1'b0;
      tod_sh  <= '0;
      ss_sh   <= S_INIT;
    end else begin
      if (prot_we && bus_addr == ADDR_CTRL) live_rd <= bus_wdata[CTRL_LIVE_BIT];
      tod_sh <= tod;
      ss_sh  <= subsec;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_TIME:   bus_rdata[TOD_W-1:0] = live_rd ? tod : tod_sh;
      ADDR_CTRL:   bus_rdata[CTRL_LIVE_BIT] = live_rd;
      ADDR_STAT: begin
        bus_rdata[STAT_REQ_BIT] = init_req;
        bus_rdata[STAT_ACK_BIT] = init_ack;
      end
      ADDR_PRE: begin
        bus_rdata[PRE_ASYNC_LSB +: AW] = a_div;
        bus_rdata[SW-1:0] = s_div;
      end
      ADDR_SUBSEC: bus_rdata[SW-1:0] = live_rd ? subsec : ss_sh;
      default: ;
    endcase
  end

  // R3: a locked write cannot change the read mode
  a_r3_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !unlocked) |=> $stable(live_rd));

  // R5: the divider values only change under an acknowledged init
  a_r5_pre_guard: assert property (@(posedge clk) disable iff (!rst_n)
    !init_ack |=> ($stable(a_div) && $stable(s_div)));

  // R5: without acknowledge the time only moves by counting
  a_r5_time_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_ack && !sec_step) |=> $stable(tod));

endmodule

// File: tb/test_rtc_core.sv
`timescale 1ns/100ps
module test_rtc_core;

  localparam int AW = 3, SW = 4, ARST = 1, SRST = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rtc_core #(.AW(AW), .SW(SW), .ARST(ARST), .SRST(SRST)) i_rtc_core (
    .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; #0.5;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] to_bcd(input int s);
    int h, m, x;
    h = s / 3600; m = (s / 60) % 60; x = s % 60;
    return ((h / 10) << 20) | ((h % 10) << 16) | ((m / 10) << 12) |
           ((m % 10) << 8) | ((x / 10) << 4) | (x % 10);
  endfunction

  // Enter init, load dividers and start time, release and follow every cycle.
  task automatic run_seq(input int a, input int s, input int start, input bit live,
                         input int ncyc, input string tag);
    logic [31:0] v, t, ss, st;
    wr(8'h0C, 32'h80);
    repeat (3) @(posedge clk);
    #1;
    wr(8'h10, (a << 16) | s);
    wr(8'h00, to_bcd(start));
    wr(8'h08, live ? 32'h20 : 32'h0);
    rd(8'h10, v); chk({tag, " R5 prescaler load"}, v, (a << 16) | s);
    rd(8'h00, v); chk({tag, " R5 time load"}, v, to_bcd(start));
    wr(8'h0C, 32'h0);
    for (int j = 0; j <= ncyc; j++) begin
      int n, m, ticks;
      @(negedge clk);
      bus_addr = 8'h00; #0.4; t = bus_rdata;
      bus_addr = 8'h28; #0.4; ss = bus_rdata;
      bus_addr = 8'h0C; #0.4; st = bus_rdata;
      if (j == 0) chk({tag, " R4 ack held after clear"}, st, 32'h40);
      if (j == 1) chk({tag, " R4 ack dropped"}, st, 32'h00);
      n = (j > 0) ? j - 1 : 0;
      m = live ? n : ((j > 1) ? j - 2 : 0);
      ticks = m / (a + 1);
      chk({tag, " R6 subsecond"}, ss, s - (ticks % (s + 1)));
      chk({tag, " R7 time"}, t, to_bcd((start + ticks / (s + 1)) % 86400));
    end
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    // R1 reset state, sampled while reset is held
    #3;
    bus_addr = 8'h00; #0.5; chk("R1 time", bus_rdata, 32'h0);
    bus_addr = 8'h08; #0.5; chk("R1 control", bus_rdata, 32'h0);
    bus_addr = 8'h0C; #0.5; chk("R1 status", bus_rdata, 32'h0);
    bus_addr = 8'h10; #0.5; chk("R1 prescaler", bus_rdata, (ARST << 16) | SRST);
    bus_addr = 8'h28; #0.5; chk("R1 subsecond", bus_rdata, SRST);
    bus_addr = 8'h24; #0.5; chk("R2 key reads zero", bus_rdata, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R3 locked writes ignored
    wr(8'h08, 32'h20); rd(8'h08, v); chk("R3 control locked", v, 32'h0);
    wr(8'h0C, 32'h80); rd(8'h0C, v); chk("R3 status locked", v, 32'h0);

    // R2 unlock sequence
    wr(8'h24, 32'hCA); wr(8'h24, 32'h11); wr(8'h24, 32'h53);
    wr(8'h08, 32'h20); rd(8'h08, v); chk("R2 wrong value between keys", v, 32'h0);
    wr(8'h24, 32'h53); wr(8'h24, 32'hCA);
    wr(8'h08, 32'h20); rd(8'h08, v); chk("R2 half sequence stays locked", v, 32'h0);
    wr(8'h24, 32'h53);
    wr(8'h08, 32'h20); rd(8'h08, v); chk("R2 unlocked", v, 32'h20);
    wr(8'h24, 32'hFF);
    wr(8'h08, 32'h00); rd(8'h08, v); chk("R2 relocked by 0xFF", v, 32'h20);
    wr(8'h24, 32'hCA); wr(8'h24, 32'hCA); wr(8'h24, 32'h53);
    wr(8'h08, 32'h20); wr(8'h08, 32'h00); rd(8'h08, v);
    chk("R2 repeated first key restarts", v, 32'h0);
    wr(8'h08, 32'h20);

    // R4 acknowledge timing, R5 acceptance while acknowledged
    wr(8'h0C, 32'h80);
    rd(8'h0C, v); chk("R4 ack low after request edge", v, 32'h80);
    rd(8'h0C, v); chk("R4 ack low one edge later", v, 32'h80);
    rd(8'h0C, v); chk("R4 ack high two edges later", v, 32'hC0);
    wr(8'h00, 32'h010203);
    rd(8'h00, v); chk("R5 time written in init", v, 32'h010203);
    rd(8'h28, v); chk("R4 subsecond held at divider", v, SRST);
    rd(8'h28, v); chk("R4 subsecond still held", v, SRST);
    rd(8'h00, v); chk("R4 time frozen", v, 32'h010203);

    // R5 writes in the window where request is set but not yet acknowledged
    wr(8'h0C, 32'h00);
    wr(8'h0C, 32'h80);
    wr(8'h00, 32'h123456);
    wr(8'h10, 32'h00020003);
    rd(8'h00, v); chk("R5 time write ignored", v, 32'h010203);
    rd(8'h10, v); chk("R5 prescaler write ignored", v, (ARST << 16) | SRST);
    rd(8'h0C, v); chk("R4 ack back high", v, 32'hC0);

    // counting runs across carries and the day wrap
    run_seq(1, 2, 86398, 1'b1, 30, "R6 R7 R8 live day wrap");
    run_seq(0, 3, 3599,  1'b0, 24, "R9 delayed reads hour carry");
    run_seq(2, 0, 35999, 1'b1, 12, "R7 ten-hour carry");
    run_seq(0, 0, 0,     1'b1, 86402, "R7 R8 full day sweep");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule